// File: doc/BRIEF.md
# Adaptive Back-EMF Blanking Timer

This block hides the false comparator transitions that a sensorless three-phase spindle drive sees right after each commutation. It measures the time between valid back-EMF zero crossings. It then blanks the comparator for about a quarter of that time after every rising commutation edge, which is 15 electrical degrees at steady speed. Everything runs on the reference clock. A shared free-running prescaler gives two single-cycle enables. The period counter steps on the fast enable. The blanking counter steps on the slow enable, which runs at half that rate.

At each qualified crossing, the period count is captured and reduced to its upper bits. The count then clears so that the next interval can be timed. At low speed, the period counter stops at its all-ones value, which gives the longest blanking window. The counter also starts in that state after reset. The comparator and the commutation inputs are asynchronous, so both pass through flop synchronizers before edge detection.

Top module: `bemf_mask_timer`

## Requirements
- R1: While reset is asserted and in the first cycles after release, with no input activity, `mask_o` and `zc_o` are both low.
- R2: The period counter advances by one on each period tick, which occurs once every 2^DIV_LOG2 reference cycles. Every qualified crossing captures the counter's value and clears it to zero in the same cycle.
- R3: The period counter saturates at 2^PER_W-1 and holds there. It also holds that value after reset, so a commutation before any crossing yields the maximum reload of 2^MASK_W-1.
- R4: The reload value is the captured period count shifted right by PER_W-MASK_W, which is its upper MASK_W bits. After a rising commutation edge, `mask_o` stays high for `reload` blanking ticks, with one blanking tick every 2^(DIV_LOG2+1) cycles. This gives between (reload-1)*2^(DIV_LOG2+1)+1 and reload*2^(DIV_LOG2+1) cycles, because the first tick may be partial.
- R5: A reload value of zero produces no blanking window: `mask_o` stays low.
- R6: Each comparator transition, rising or falling, that arrives while `mask_o` is low gives exactly one single-cycle `zc_o` pulse. The pulse comes after the two-flop synchronizer.
- R7: Comparator transitions that occur while `mask_o` is high give no `zc_o` pulse. They also leave the captured reload value unchanged.
- R8: Blanking starts only on a rising commutation edge. Holding `comm_i` high does not start a second window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comm_i | input | 1 | Commutation clock from the sequencer (asynchronous) |
| cmp_i | input | 1 | Raw back-EMF comparator output (asynchronous) |
| mask_o | output | 1 | High while zero crossings are blanked |
| zc_o | output | 1 | Single-cycle pulse on each qualified zero crossing |

## Verification
The bench builds the block with DIV_LOG2 = 3, and keeps PER_W = 9 and MASK_W = 6. With these values, one period tick is 8 cycles and one blanking tick is 16 cycles. Saturation of the period counter therefore takes only about 4,100 cycles, and the maximum window is about 1,000 cycles. This makes it practical to cover all of the following in one run:
- random crossing intervals that span the whole proportional range;
- the saturated start after reset;
- the reload-of-zero and reload-of-one boundaries;
- blanked transitions and a held commutation level.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  typedef struct packed {
    logic per;
    logic msk;
  } bmt_tick_t;
endpackage

// File: rtl/bmt_prescaler.sv
module bmt_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output bmt_pkg::bmt_tick_t tick_o
);
  localparam int PW = DIV_LOG2 + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + ONE;
  end

  // fast tick every 2^DIV_LOG2 cycles, slow tick at half that rate
  assign tick_o.per = &pre_q[DIV_LOG2-1:0];
  assign tick_o.msk = &pre_q;
endmodule

// File: rtl/bmt_edge_sync.sv
module bmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/bmt_period_meter.sv
module bmt_period_meter #(
  parameter int PER_W  = 9,
  parameter int MASK_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              zc_i,
  output logic [MASK_W-1:0] rel_o
);
  localparam int SHIFT = PER_W - MASK_W;
  localparam logic [PER_W-1:0] PMAX = '1;
  localparam logic [PER_W-1:0] ONE  = PER_W'(1);

  logic [PER_W-1:0]  per_q;
  logic [MASK_W-1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= PMAX;
      rel_q <= '1;
    end else if (zc_i) begin
      rel_q <= per_q[PER_W-1:SHIFT];
      per_q <= '0;
    end else if (tick_i && per_q != PMAX) begin
      per_q <= per_q + ONE;
    end
  end

  assign rel_o = rel_q;

  AST_PER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_i |=> per_q == '0); // R2
  AST_PER_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == PMAX && !zc_i) |=> per_q == PMAX); // R3
  AST_REL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_i |=> $stable(rel_q)); // R7
endmodule

// File: rtl/bmt_mask_counter.sv
module bmt_mask_counter #(
  parameter int MASK_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MASK_W-1:0] val_i,
  input  logic              tick_i,
  output logic              mask_o
);
  localparam logic [MASK_W-1:0] ONE = MASK_W'(1);

  logic [MASK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign mask_o = |cnt_q;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i)); // R4
  AST_MASK_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R5
  AST_MASK_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q <= $past(cnt_q)); // R4
endmodule

// File: rtl/bemf_mask_timer.sv
module bemf_mask_timer #(
  parameter int DIV_LOG2    = 6,
  parameter int PER_W       = 9,
  parameter int MASK_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic comm_i,
  input  logic cmp_i,
  output logic mask_o,
  output logic zc_o
);
  bmt_pkg::bmt_tick_t tick;
  logic cmp_rise, cmp_fall, comm_rise, comm_fall;
  logic zc;
  logic [MASK_W-1:0] rel;

  bmt_prescaler #(.DIV_LOG2(DIV_LOG2)) i_pre (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  bmt_edge_sync #(.STAGES(SYNC_STAGES)) i_cmp_sync (
    .clk_i, .rst_ni, .d_i(cmp_i), .rise_o(cmp_rise), .fall_o(cmp_fall)
  );

  bmt_edge_sync #(.STAGES(SYNC_STAGES)) i_comm_sync (
    .clk_i, .rst_ni, .d_i(comm_i), .rise_o(comm_rise), .fall_o(comm_fall)
  );

  // either polarity qualifies, only outside the blanking window
  assign zc = (cmp_rise | cmp_fall) & ~mask_o;

  bmt_period_meter #(.PER_W(PER_W), .MASK_W(MASK_W)) i_per (
    .clk_i, .rst_ni, .tick_i(tick.per), .zc_i(zc), .rel_o(rel)
  );

  bmt_mask_counter #(.MASK_W(MASK_W)) i_msk (
    .clk_i, .rst_ni, .load_i(comm_rise), .val_i(rel),
    .tick_i(tick.msk), .mask_o(mask_o)
  );

  assign zc_o = zc;

  AST_COMM_LEVEL_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comm_rise || (!comm_fall && $past(comm_rise))) |=> !comm_rise); // R8

  logic unused_fall;
  assign unused_fall = comm_fall;
endmodule

// File: tb/test_bemf_mask_timer.sv
module test_bemf_mask_timer;
  localparam int D      = 3;
  localparam int PER_W  = 9;
  localparam int MASK_W = 6;
  localparam int PTK    = 1 << D;
  localparam int MTK    = 1 << (D + 1);
  localparam int PMAX   = (1 << PER_W) - 1;
  localparam int SH     = PER_W - MASK_W;
  localparam int RMAX   = (1 << MASK_W) - 1;
  localparam int WIN    = (RMAX + 1) * MTK + 20;

  logic clk = 1'b0;
  logic rst_ni, comm_i, cmp_i;
  logic mask_o, zc_o;

  int checks = 0, errors = 0;
  int zc_cnt = 0, msk_cnt = 0;

  always #2.5 clk = ~clk;

  bemf_mask_timer #(.DIV_LOG2(D), .PER_W(PER_W), .MASK_W(MASK_W)) i_bemf_mask_timer (
    .clk_i(clk), .rst_ni, .comm_i, .cmp_i, .mask_o, .zc_o
  );

  task automatic check(input bit ok, input string req, input int act, input int lo, input int hi);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (zc_o)   zc_cnt++;
      if (mask_o) msk_cnt++;
    end
  endtask

  function automatic int lo_len(input int rel);
    return (rel == 0) ? 0 : (rel - 1) * MTK + 1;
  endfunction

  task automatic measure(input int rmin, input int rmax, input string req);
    msk_cnt = 0;
    comm_i = 1'b1;
    wait_cyc(4);
    comm_i = 1'b0;
    wait_cyc(WIN);
    check(msk_cnt >= lo_len(rmin) && msk_cnt <= rmax * MTK, req, msk_cnt, lo_len(rmin), rmax * MTK);
  endtask

  // two unmasked crossings T cycles apart, then a commutation
  task automatic trial(input int t);
    int kmin, kmax;
    kmin = (t - 1) / PTK;
    if (kmin > PMAX) kmin = PMAX;
    kmax = (kmin + 1 > PMAX) ? PMAX : kmin + 1;
    zc_cnt = 0;
    cmp_i = ~cmp_i;
    wait_cyc(t);
    cmp_i = ~cmp_i;
    wait_cyc(6);
    check(zc_cnt == 2, "R6", zc_cnt, 2, 2);
    measure(kmin >> SH, kmax >> SH, "R2 R4");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; comm_i = 1'b0; cmp_i = 1'b0;
    wait_cyc(5);
    check(mask_o == 1'b0, "R1", int'(mask_o), 0, 0);
    rst_ni = 1'b1;
    wait_cyc(3);
    check(mask_o == 1'b0 && zc_o == 1'b0, "R1", int'(mask_o) + int'(zc_o), 0, 0);

    // R3: no crossing yet, counter starts saturated
    measure(RMAX, RMAX, "R3");

    // directed corners
    trial(20);              // reload 0: no window (R5)
    check(mask_o == 1'b0, "R5", int'(mask_o), 0, 0);
    trial(8 * PTK + 1);     // reload exactly 1
    trial(PMAX * PTK + 600); // beyond range: saturated (R3)

    // R7: transitions inside the window are ignored
    zc_cnt = 0;
    msk_cnt = 0;
    comm_i = 1'b1;
    wait_cyc(4);
    comm_i = 1'b0;
    wait_cyc(100);
    cmp_i = ~cmp_i;
    wait_cyc(100);
    cmp_i = ~cmp_i;
    wait_cyc(WIN - 200);
    check(zc_cnt == 0, "R7", zc_cnt, 0, 0);
    check(msk_cnt >= lo_len(RMAX) && msk_cnt <= RMAX * MTK, "R7", msk_cnt, lo_len(RMAX), RMAX * MTK);
    measure(RMAX, RMAX, "R7");

    // R8: level held high starts only one window
    msk_cnt = 0;
    comm_i = 1'b1;
    wait_cyc(2 * WIN);
    comm_i = 1'b0;
    wait_cyc(10);
    check(msk_cnt >= lo_len(RMAX) && msk_cnt <= RMAX * MTK, "R8", msk_cnt, lo_len(RMAX), RMAX * MTK);

    // random intervals across the proportional range
    for (int n = 0; n < 20; n++) begin
      trial(20 + int'($urandom % 4500));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule